// File: doc/BRIEF.md
# Debug-Link Flash Mass-Erase Sequencer

This block takes a target microcontroller through a debug-session entry and a full flash erase. When it receives a start pulse, it pulls the target's active-low reset and debug-enable pins low together. It then releases reset, and releases debug-enable after a fixed delay. After a short settling wait it sends a fixed stream of command bytes over a valid/ready byte channel. A separate serializer, outside this block, carries those bytes to the target's on-chip debugger.

The stream is built from three kinds of item. The first is an autobaud byte, which opens each group of register writes. The second is a set of five-byte single-register write frames that configure the oscillator and the flash timing word. The third is a two-key unlock of the flash controller. A long pause follows the unlock. After the pause come a fresh autobaud and the mass-erase command.

Every delay is converted to clock cycles at elaboration from the `CLK_HZ` parameter. The flash timing word is also derived from `CLK_HZ`. The block shows `busy` for the whole session and pulses `done` once at the end.

Top module: `dbg_erase_seq`

## Requirements
- R1: While reset is applied and after it is released, `tgt_rst_n` and `tgt_dbg_n` are high, and `tx_valid`, `busy` and `done` are low.
- R2: A start pulse sampled while the block is not busy drives both `tgt_rst_n` and `tgt_dbg_n` low from the next cycle, for exactly HOLD cycles, with `busy` high.
- R3: `tgt_rst_n` rises first. `tgt_dbg_n` rises exactly RSTDBG cycles later, and it is never high while `tgt_rst_n` is low.
- R4: After `tgt_dbg_n` rises, `tx_valid` stays low for exactly SETTLE cycles before the first byte is offered. No byte is offered while `tgt_dbg_n` is low.
- R5: The stream is 43 bytes long. Byte 0x80 (autobaud) sits at stream positions 0, 26 and 37. Every other byte belongs to a write frame of the form 0x08, 0x0F, address, 0x01, data. `tx_valid` has no gap anywhere in the stream except after position 36.
- R6: Frames 1 to 3 write address 0x86 with the data values 0xE2, then 0x18, then 0xE7.
- R7: Frames 4 and 5 write the timing word floor(CLK_HZ/1000). The high byte goes to address 0xFA, then the low byte goes to address 0xFB.
- R8: Address 0xF8 is written with 0x73 and then 0x8C. After that, `tx_valid` is low for exactly ERASE_WAIT cycles. Then 0x80 and a write of 0x63 to address 0xF8 follow.
- R9: The stream advances only on a cycle in which `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R10: `done` is high for exactly one cycle, the cycle after the last byte is accepted. In that cycle `busy` is already low.
- R11: A start pulse while `busy` is high is ignored. The pins stay released and the byte stream continues unchanged.
- R12: Each delay equals ceil(CLK_HZ × time / 1e6) cycles, with a minimum of 1. The times are HOLD 1 ms, RSTDBG 5 ms, SETTLE 20 us and ERASE_WAIT 250 ms. CLK_HZ must be at least 32 kHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse for one session |
| tx_ready | input | 1 | Byte sink ready |
| tx_valid | output | 1 | Command byte offered |
| tx_data | output | 8 | Command byte |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse at session end |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_dbg_n | output | 1 | Target debug enable, active low |

## Verification
The bound checker checks the following on every cycle:
- the release order of the two pins;
- that no byte is offered while debug-enable is asserted;
- that data is held during back-pressure;
- that `done` is a single-cycle pulse with `busy` low;
- that `busy` stays high while no byte is being handed over.

Only the bench scenarios can show the following:
- the exact cycle counts of each delay, including the rounding up of the 20 us settle;
- the full 43-byte order with the frequency word computed from the clock;
- the length of the post-unlock gap;
- that a start pulse in the middle of a session leaves the stream intact, under both a continuously ready sink and a stalling one.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_RST_REL, ST_DBG_REL,
    ST_SEND_A, ST_WAIT, ST_SEND_B, ST_DONE
  } seq_state_t;

  localparam int unsigned N_BYTES = 43;
  localparam int unsigned LAST_A  = 36;

  // Round up to whole cycles, never less than one.
  function automatic int unsigned us_to_cyc(longint unsigned hz, longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

  // Byte at stream position i, given the flash timing word fw.
  function automatic logic [7:0] frame_byte(int i, logic [15:0] fw);
    logic [7:0] a;
    logic [7:0] d;
    int k;
    int p;
    if (i == 0 || i == 26 || i == 37) return 8'h80;
    if (i < 26) begin
      k = (i - 1) / 5;
      p = (i - 1) % 5;
      case (k)
        0:       begin a = 8'h86; d = 8'hE2;     end
        1:       begin a = 8'h86; d = 8'h18;     end
        2:       begin a = 8'h86; d = 8'hE7;     end
        3:       begin a = 8'hFA; d = fw[15:8]; end
        default: begin a = 8'hFB; d = fw[7:0];  end
      endcase
    end else if (i < 37) begin
      k = (i - 27) / 5;
      p = (i - 27) % 5;
      a = 8'hF8;
      d = (k == 0) ? 8'h73 : 8'h8C;
    end else begin
      p = i - 38;
      a = 8'hF8;
      d = 8'h63;
    end
    case (p)
      0:       return 8'h08;
      1:       return 8'h0F;
      2:       return a;
      3:       return 8'h01;
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dbgseq_rst_sync.sv
module dbgseq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dbgseq_timer.sv
module dbgseq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dbgseq_rom.sv
module dbgseq_rom
  import dbgseq_pkg::*;
#(
  parameter int unsigned IW        = 6,
  parameter logic [15:0] FREQ_WORD = 16'h4E20
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    data
);
  always_comb data = frame_byte(int'(idx), FREQ_WORD);
endmodule

// File: rtl/dbgseq_ctrl.sv
module dbgseq_ctrl
  import dbgseq_pkg::*;
#(
  parameter int unsigned TW         = 8,
  parameter int unsigned IW         = 6,
  parameter int unsigned HOLD_CYC   = 4,
  parameter int unsigned RSTDBG_CYC = 4,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned WAIT_CYC   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tx_ready,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic [IW-1:0] idx,
  output logic          tx_valid,
  output logic          busy,
  output logic          done,
  output logic          tgt_rst_n,
  output logic          tgt_dbg_n
);
  localparam logic [TW-1:0] HOLD_V   = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] RSTDBG_V = TW'(RSTDBG_CYC - 1);
  localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] WAIT_V   = TW'(WAIT_CYC - 1);
  localparam logic [IW-1:0] IDX_A    = IW'(LAST_A);
  localparam logic [IW-1:0] IDX_END  = IW'(N_BYTES - 1);

  seq_state_t    state_q, state_d;
  logic [IW-1:0] idx_q;
  logic          idx_clr, idx_inc, accept;

  assign tx_valid = (state_q == ST_SEND_A) || (state_q == ST_SEND_B);
  assign accept   = tx_valid && tx_ready;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        state_d = ST_IDLE;
        if (start) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_V;
          idx_clr  = 1'b1;
        end
      end
      ST_HOLD: if (tmr_expired) begin
        state_d  = ST_RST_REL;
        tmr_load = 1'b1;
        tmr_val  = RSTDBG_V;
      end
      ST_RST_REL: if (tmr_expired) begin
        state_d  = ST_DBG_REL;
        tmr_load = 1'b1;
        tmr_val  = SETTLE_V;
      end
      ST_DBG_REL: if (tmr_expired) state_d = ST_SEND_A;
      ST_SEND_A: if (accept) begin
        idx_inc = 1'b1;
        if (idx_q == IDX_A) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = WAIT_V;
        end
      end
      ST_WAIT: if (tmr_expired) state_d = ST_SEND_B;
      ST_SEND_B: if (accept) begin
        if (idx_q == IDX_END) state_d = ST_DONE;
        else                  idx_inc = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (idx_clr) idx_q <= '0;
    else if (idx_inc) idx_q <= idx_q + 1'b1;
  end

  assign idx       = idx_q;
  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign tgt_rst_n = (state_q != ST_HOLD);
  assign tgt_dbg_n = (state_q != ST_HOLD) && (state_q != ST_RST_REL);
endmodule

// File: rtl/dbg_erase_seq.sv
module dbg_erase_seq
  import dbgseq_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 20_000_000,
  parameter int unsigned HOLD_US       = 1_000,
  parameter int unsigned RSTDBG_US     = 5_000,
  parameter int unsigned SETTLE_US     = 20,
  parameter int unsigned ERASE_WAIT_US = 250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       busy,
  output logic       done,
  output logic       tgt_rst_n,
  output logic       tgt_dbg_n
);
  localparam int unsigned HOLD_CYC   = us_to_cyc(CLK_HZ, HOLD_US);
  localparam int unsigned RSTDBG_CYC = us_to_cyc(CLK_HZ, RSTDBG_US);
  localparam int unsigned SETTLE_CYC = us_to_cyc(CLK_HZ, SETTLE_US);
  localparam int unsigned WAIT_CYC   = us_to_cyc(CLK_HZ, ERASE_WAIT_US);
  localparam int unsigned MAX_AB     = (HOLD_CYC > RSTDBG_CYC) ? HOLD_CYC : RSTDBG_CYC;
  localparam int unsigned MAX_CD     = (SETTLE_CYC > WAIT_CYC) ? SETTLE_CYC : WAIT_CYC;
  localparam int unsigned MAX_CYC    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned TW         = $clog2(MAX_CYC + 1);
  localparam int unsigned IW         = $clog2(N_BYTES);
  localparam logic [15:0] FREQ_WORD  = 16'(CLK_HZ / 1000);

  logic          rst_sync_n;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic [IW-1:0] idx;

  dbgseq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dbgseq_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dbgseq_ctrl #(
    .TW(TW), .IW(IW), .HOLD_CYC(HOLD_CYC), .RSTDBG_CYC(RSTDBG_CYC),
    .SETTLE_CYC(SETTLE_CYC), .WAIT_CYC(WAIT_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .tx_ready    (tx_ready),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .idx         (idx),
    .tx_valid    (tx_valid),
    .busy        (busy),
    .done        (done),
    .tgt_rst_n   (tgt_rst_n),
    .tgt_dbg_n   (tgt_dbg_n)
  );

  dbgseq_rom #(.IW(IW), .FREQ_WORD(FREQ_WORD)) u_rom (
    .idx  (idx),
    .data (tx_data)
  );
endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       busy,
  input logic       done,
  input logic       tgt_rst_n,
  input logic       tgt_dbg_n
);
  p_dbg_after_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> !tgt_dbg_n);

  p_quiet_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_dbg_n |-> !tx_valid);

  p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tx_valid && tgt_rst_n && tgt_dbg_n));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_valid) |=> busy);
endmodule

bind dbg_erase_seq dbgseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tx_ready  (tx_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .busy      (busy),
  .done      (done),
  .tgt_rst_n (tgt_rst_n),
  .tgt_dbg_n (tgt_dbg_n)
);

// File: tb/sim_dbg_erase_seq.sv
module sim_dbg_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 75_000;
  // Expected delays: ceil(HZ * us / 1e6), at least 1
  localparam int E_HOLD     = (HZ * 1000 + 999_999) / 1_000_000;
  localparam int E_RSTDBG   = (HZ * 5 + 999) / 1000;
  localparam int E_SETTLE   = 2;   // 20 us at 75 kHz = 1.5 cycles, rounded up
  localparam int E_WAIT     = (HZ / 4);
  localparam int FW         = HZ / 1000;

  logic       clk = 1'b0;
  logic       rst_n, start, tx_ready;
  logic       tx_valid, busy, done, tgt_rst_n, tgt_dbg_n;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] exp_s [43];
  logic [7:0] lfsr = 8'hA5;

  dbg_erase_seq #(.CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy), .done(done),
    .tgt_rst_n(tgt_rst_n), .tgt_dbg_n(tgt_dbg_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200_000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <200000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, expv);
    end
  endtask

  function automatic string tag_of(int i);
    if (i >= 1 && i <= 15)  return "R6";
    if (i >= 16 && i <= 25) return "R7";
    if (i >= 27)            return "R8";
    return "R5";
  endfunction

  task automatic build_stream();
    int n = 0;
    logic [7:0] ad [8] = '{8'h86, 8'h86, 8'h86, 8'hFA, 8'hFB, 8'hF8, 8'hF8, 8'hF8};
    logic [7:0] dt [8];
    dt = '{8'hE2, 8'h18, 8'hE7, 8'(FW >> 8), 8'(FW & 255), 8'h73, 8'h8C, 8'h63};
    for (int f = 0; f < 8; f++) begin
      if (f == 0 || f == 5 || f == 7) begin exp_s[n] = 8'h80; n++; end
      exp_s[n] = 8'h08; exp_s[n+1] = 8'h0F; exp_s[n+2] = ad[f];
      exp_s[n+3] = 8'h01; exp_s[n+4] = dt[f];
      n += 5;
    end
  endtask

  task automatic session(input bit stall, input bit poke);
    int n;
    int idx = 0;
    int gap = 0;
    int other_gap = 0;
    bit prev_stall = 0;
    bit poked = 0;
    bit poke_now = 0;
    logic [7:0] prev_byte = 8'h00;
    bit r;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !tgt_dbg_n, "R2 busy/dbg low", {busy, tgt_dbg_n}, 2);
    n = 0; while (!tgt_rst_n) begin n++; @(negedge clk); end
    chk(n == E_HOLD, "R2 hold cycles", n, E_HOLD);
    n = 0; while (!tgt_dbg_n) begin n++; @(negedge clk); end
    chk(n == E_RSTDBG, "R3 reset-to-debug cycles", n, E_RSTDBG);
    n = 0; while (!tx_valid) begin n++; @(negedge clk); end
    chk(n == E_SETTLE, "R4 R12 settle cycles", n, E_SETTLE);
    while (idx < 43) begin
      if (poke_now) begin
        chk(tgt_rst_n && tgt_dbg_n && busy, "R11 start ignored", {tgt_rst_n, tgt_dbg_n, busy}, 7);
        poke_now = 0;
      end
      if (prev_stall)
        chk(tx_valid && tx_data == prev_byte, "R9 stall hold", tx_data, prev_byte);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      r = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      tx_ready = r;
      if (poke && idx == 10 && !poked) begin start = 1'b1; poked = 1; poke_now = 1; end
      else start = 1'b0;
      prev_stall = tx_valid && !r;
      prev_byte  = tx_data;
      if (tx_valid) begin
        if (r) begin
          chk(tx_data == exp_s[idx], tag_of(idx), tx_data, exp_s[idx]);
          idx++;
        end
      end else if (idx == 37) gap++;
      else other_gap++;
      @(negedge clk);
    end
    start = 1'b0;
    tx_ready = 1'b0;
    chk(gap == E_WAIT, "R8 erase wait cycles", gap, E_WAIT);
    chk(other_gap == 0, "R5 no other gaps", other_gap, 0);
    chk(done && !busy, "R10 done pulse", {done, busy}, 2);
    @(negedge clk);
    chk(!done && !busy && !tx_valid && tgt_rst_n, "R10 done one cycle", {done, busy, tx_valid}, 0);
  endtask

  initial begin
    build_stream();
    rst_n = 1'b0; start = 1'b0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(tgt_rst_n && tgt_dbg_n && !tx_valid && !busy && !done, "R1 in reset",
        {tgt_rst_n, tgt_dbg_n, tx_valid, busy, done}, 5'b11000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tgt_rst_n && tgt_dbg_n && !tx_valid && !busy && !done, "R1 after reset",
        {tgt_rst_n, tgt_dbg_n, tx_valid, busy, done}, 5'b11000);
    session(1'b0, 1'b0);
    session(1'b1, 1'b1);
    session(1'b1, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule